// File: doc/BRIEF.md
# Trigger Class Condition Evaluator

Once per bunch crossing this block looks at the level-0 trigger inputs and decides, for each configured trigger class, whether that class fires. Each class has its own input condition. The condition is a pure AND over a chosen subset of inputs, and each chosen input can be required high or low. A 4-input lookup table derives one extra input from four selectable trigger inputs. This lets a class require an arbitrary function, such as an interaction definition, which plain AND terms cannot express.

A class that matches still has to pass its gates before it fires. The gates are:
- an optional bunch-crossing mask;
- an optional random-trigger source;
- an optional past/future protection flag;
- a rare-only gate, used while the readout buffers report nearly full;
- a per-class downscaler that passes one of every N qualified matches.

Every class maps to one output cluster. The block registers the fired-class vector and the per-cluster OR one clock after sampling. It also keeps two wrap-around scalers per class: one counts raw matches and one counts fires. Comparing the two accounts for rejections.

Top module: `trig_class_eval`

## Requirements
- R1: While reset is active, and after it is released, every output is zero: the class vector, the cluster vector and all scalers. All downscalers start at count zero.
- R2: A class matches when every bit set in its use mask agrees with the extended input vector. Polarity bit 0 requires the bit high and polarity bit 1 requires it low. Bits outside the use mask have no effect.
- R3: Bit N_IN of the extended vector is `lut_tab[addr]`. The address `addr` is four bits, least significant first, taken from `trig_in` at the indices in `lut_sel` fields 0 to 3 (field i is `lut_sel[i*SEL_W +: SEL_W]`).
- R4: A class with an all-zero use mask never fires and never counts a match.
- R5: A class with its mask enable set fires only when `bc_mask[sel]` is high. The random enable requires `rnd_trig[sel]` high, and the protection enable requires `pf_ok` high.
- R6: While `daq_full` is high, only classes with `cls_rare` set may fire. When it is low, all classes may fire.
- R7: A per-class counter advances only on cycles where the match and all gates hold. The class fires on such a cycle when the counter is zero. The counter then returns to zero if count+1 >= divisor, and otherwise increments. A divisor of 0 or 1 therefore passes every qualified match.
- R8: `class_fired` reflects the inputs sampled at a clock edge and is valid right after that edge.
- R9: `cluster_fired[k]` is the OR of the fired classes whose cluster index equals k. A class whose index is N_CLU or above drives no cluster. Both outputs are registered together.
- R10: The match scaler of a class adds one on every edge where its AND condition holds, regardless of gates. The fired scaler adds one on every fire. Both wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | N_IN | Level-0 trigger inputs |
| bc_mask | input | N_BCM | Bunch-crossing mask bits for this crossing |
| rnd_trig | input | N_RND | Random trigger sources |
| pf_ok | input | 1 | Past/future protection passed |
| daq_full | input | 1 | Readout buffers nearly full |
| lut_sel | input | 4*SEL_W | Input indices feeding the lookup table |
| lut_tab | input | 16 | Lookup table contents |
| cls_use | input | N_CLS*X_W | Per-class use mask over the extended vector |
| cls_pol | input | N_CLS*X_W | Per-class polarity (1 = require low) |
| cls_bcm_en | input | N_CLS | Per-class mask gate enable |
| cls_bcm_sel | input | N_CLS*BCM_W | Per-class mask select |
| cls_rnd_en | input | N_CLS | Per-class random gate enable |
| cls_rnd_sel | input | N_CLS*RND_W | Per-class random select |
| cls_pf_en | input | N_CLS | Per-class protection gate enable |
| cls_rare | input | N_CLS | Per-class rare flag |
| cls_div | input | N_CLS*DS_W | Per-class downscale divisor |
| cls_clu | input | N_CLS*CLU_W | Per-class cluster index |
| class_fired | output | N_CLS | Registered fired-class vector |
| cluster_fired | output | N_CLU | Registered per-cluster OR |
| scl_match | output | N_CLS*CNT_W | Per-class match scalers |
| scl_fired | output | N_CLS*CNT_W | Per-class fired scalers |

## Verification
Some properties are checked by assertions on every cycle:
- an empty use mask never yields a fire;
- the rare gate holds back non-rare classes while buffers are full;
- the protection flag gates any class that enables it;
- every fired class shows up on its cluster;
- a downscaled class never fires on two consecutive edges;
- the fired scaler never moves without the match scaler.

Other behaviour only the bench's reference model can show:
- the exact polarity semantics;
- the lookup-table address ordering;
- the downscale phase across interrupted match runs;
- the exact scaler values.

// File: rtl/cte_pkg.sv
package cte_pkg;
  localparam int LUT_IN = 4;
  localparam int LUT_N  = 1 << LUT_IN;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cte_lut.sv
module cte_lut #(
  parameter int N_IN  = 24,
  parameter int SEL_W = 5
) (
  input  logic [N_IN-1:0]                    trig_in,
  input  logic [cte_pkg::LUT_IN*SEL_W-1:0]   sel,
  input  logic [cte_pkg::LUT_N-1:0]          tab,
  output logic                               lut_out
);
  logic [cte_pkg::LUT_IN-1:0] addr;

  generate
    for (genvar i = 0; i < cte_pkg::LUT_IN; i++) begin : g_addr
      assign addr[i] = trig_in[sel[i*SEL_W +: SEL_W]];
    end
  endgenerate

  assign lut_out = tab[addr];
endmodule

// File: rtl/cte_class.sv
module cte_class #(
  parameter int X_W   = 25,
  parameter int N_BCM = 4,
  parameter int N_RND = 2,
  parameter int BCM_W = 2,
  parameter int RND_W = 1,
  parameter int DS_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [X_W-1:0]   x_in,
  input  logic [X_W-1:0]   use_m,
  input  logic [X_W-1:0]   pol_m,
  input  logic [N_BCM-1:0] bc_mask,
  input  logic             bcm_en,
  input  logic [BCM_W-1:0] bcm_sel,
  input  logic [N_RND-1:0] rnd,
  input  logic             rnd_en,
  input  logic [RND_W-1:0] rnd_sel,
  input  logic             pf_ok,
  input  logic             pf_en,
  input  logic             daq_full,
  input  logic             rare,
  input  logic [DS_W-1:0]  div,
  output logic             fire,
  output logic [CNT_W-1:0] scl_match,
  output logic [CNT_W-1:0] scl_fired
);
  logic             hit;
  logic             gate_ok;
  logic             qual;
  logic             ds_last;
  logic [DS_W-1:0]  ds_q;
  logic [DS_W-1:0]  ds_d;
  logic [CNT_W-1:0] sm_d;
  logic [CNT_W-1:0] sf_d;

  // next-state logic
  always_comb begin
    hit     = (|use_m) && ((use_m & (x_in ^ pol_m)) == use_m);
    gate_ok = (!bcm_en   || bc_mask[bcm_sel]) &&
              (!rnd_en   || rnd[rnd_sel])     &&
              (!pf_en    || pf_ok)            &&
              (!daq_full || rare);
    qual    = hit && gate_ok;
    fire    = qual && (ds_q == '0);
    ds_last = ({1'b0, ds_q} + (DS_W+1)'(1)) >= {1'b0, div};
    ds_d    = ds_last ? '0 : ds_q + DS_W'(1);
    sm_d    = scl_match + CNT_W'(1);
    sf_d    = scl_fired + CNT_W'(1);
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q <= '0;
    end else if (qual) begin
      ds_q <= ds_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_match <= '0;
    end else if (hit) begin
      scl_match <= sm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_fired <= '0;
    end else if (fire) begin
      scl_fired <= sf_d;
    end
  end

  // R7: with a divisor of two or more, no two consecutive fires
  p_ds_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && div >= DS_W'(2)) |=> !fire);

  // R10: fired scaler only moves together with the match scaler
  p_scl_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_fired) |-> !$stable(scl_match));
endmodule

// File: rtl/cte_cluster.sv
module cte_cluster #(
  parameter int N_CLS = 16,
  parameter int N_CLU = 6,
  parameter int CLU_W = 3
) (
  input  logic [N_CLS-1:0]       fired,
  input  logic [N_CLS*CLU_W-1:0] clu_map,
  output logic [N_CLU-1:0]       any_fired
);
  generate
    for (genvar k = 0; k < N_CLU; k++) begin : g_clu
      always_comb begin
        any_fired[k] = 1'b0;
        for (int c = 0; c < N_CLS; c++) begin
          if (fired[c] && (clu_map[c*CLU_W +: CLU_W] == CLU_W'(k)))
            any_fired[k] = 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/trig_class_eval.sv
module trig_class_eval #(
  parameter int N_IN  = 24,
  parameter int N_CLS = 16,
  parameter int N_CLU = 6,
  parameter int N_BCM = 4,
  parameter int N_RND = 2,
  parameter int DS_W  = 8,
  parameter int CNT_W = 16,
  localparam int X_W   = N_IN + 1,
  localparam int SEL_W = cte_pkg::idx_w(N_IN),
  localparam int BCM_W = cte_pkg::idx_w(N_BCM),
  localparam int RND_W = cte_pkg::idx_w(N_RND),
  localparam int CLU_W = cte_pkg::idx_w(N_CLU)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_IN-1:0]                  trig_in,
  input  logic [N_BCM-1:0]                 bc_mask,
  input  logic [N_RND-1:0]                 rnd_trig,
  input  logic                             pf_ok,
  input  logic                             daq_full,
  input  logic [cte_pkg::LUT_IN*SEL_W-1:0] lut_sel,
  input  logic [cte_pkg::LUT_N-1:0]        lut_tab,
  input  logic [N_CLS*X_W-1:0]             cls_use,
  input  logic [N_CLS*X_W-1:0]             cls_pol,
  input  logic [N_CLS-1:0]                 cls_bcm_en,
  input  logic [N_CLS*BCM_W-1:0]           cls_bcm_sel,
  input  logic [N_CLS-1:0]                 cls_rnd_en,
  input  logic [N_CLS*RND_W-1:0]           cls_rnd_sel,
  input  logic [N_CLS-1:0]                 cls_pf_en,
  input  logic [N_CLS-1:0]                 cls_rare,
  input  logic [N_CLS*DS_W-1:0]            cls_div,
  input  logic [N_CLS*CLU_W-1:0]           cls_clu,
  output logic [N_CLS-1:0]                 class_fired,
  output logic [N_CLU-1:0]                 cluster_fired,
  output logic [N_CLS*CNT_W-1:0]           scl_match,
  output logic [N_CLS*CNT_W-1:0]           scl_fired
);
  logic             rst_s0;
  logic             rst_core_n;
  logic             lut_bit;
  logic [X_W-1:0]   x_vec;
  logic [N_CLS-1:0] fire_d;
  logic [N_CLU-1:0] clu_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_core_n <= rst_s0;
    end
  end

  cte_lut #(.N_IN(N_IN), .SEL_W(SEL_W)) u_lut (
    .trig_in (trig_in),
    .sel     (lut_sel),
    .tab     (lut_tab),
    .lut_out (lut_bit)
  );

  assign x_vec = {lut_bit, trig_in};

  generate
    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
      cte_class #(
        .X_W(X_W), .N_BCM(N_BCM), .N_RND(N_RND), .BCM_W(BCM_W),
        .RND_W(RND_W), .DS_W(DS_W), .CNT_W(CNT_W)
      ) u_cls (
        .clk       (clk),
        .rst_n     (rst_core_n),
        .x_in      (x_vec),
        .use_m     (cls_use[c*X_W +: X_W]),
        .pol_m     (cls_pol[c*X_W +: X_W]),
        .bc_mask   (bc_mask),
        .bcm_en    (cls_bcm_en[c]),
        .bcm_sel   (cls_bcm_sel[c*BCM_W +: BCM_W]),
        .rnd       (rnd_trig),
        .rnd_en    (cls_rnd_en[c]),
        .rnd_sel   (cls_rnd_sel[c*RND_W +: RND_W]),
        .pf_ok     (pf_ok),
        .pf_en     (cls_pf_en[c]),
        .daq_full  (daq_full),
        .rare      (cls_rare[c]),
        .div       (cls_div[c*DS_W +: DS_W]),
        .fire      (fire_d[c]),
        .scl_match (scl_match[c*CNT_W +: CNT_W]),
        .scl_fired (scl_fired[c*CNT_W +: CNT_W])
      );

      // R4: empty use mask never fires
      p_empty_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
        (cls_use[c*X_W +: X_W] == '0) |=> !class_fired[c]);

      // R6: non-rare classes are held back while buffers are full
      p_rare_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
        (daq_full && !cls_rare[c]) |=> !class_fired[c]);

      // R5: protection gate
      p_pf_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
        (cls_pf_en[c] && !pf_ok) |=> !class_fired[c]);

      // R9: a fired class appears on its cluster
      p_cluster_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
        class_fired[c] |->
          (int'($past(cls_clu[c*CLU_W +: CLU_W])) >= N_CLU) ||
          cluster_fired[$past(cls_clu[c*CLU_W +: CLU_W])]);
    end
  endgenerate

  cte_cluster #(.N_CLS(N_CLS), .N_CLU(N_CLU), .CLU_W(CLU_W)) u_clu (
    .fired     (fire_d),
    .clu_map   (cls_clu),
    .any_fired (clu_d)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      class_fired   <= '0;
      cluster_fired <= '0;
    end else begin
      class_fired   <= fire_d;
      cluster_fired <= clu_d;
    end
  end
endmodule

// File: tb/trig_class_eval_tb.sv
module trig_class_eval_tb;
  localparam int N_IN  = 24;
  localparam int N_CLS = 8;
  localparam int N_CLU = 6;
  localparam int N_BCM = 4;
  localparam int N_RND = 2;
  localparam int DS_W  = 8;
  localparam int CNT_W = 16;
  localparam int X_W   = N_IN + 1;
  localparam int SEL_W = 5;
  localparam int BCM_W = 2;
  localparam int RND_W = 1;
  localparam int CLU_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IN-1:0]  trig_in = '0;
  logic [N_BCM-1:0] bc_mask = '0;
  logic [N_RND-1:0] rnd_trig = '0;
  logic pf_ok = 1'b0;
  logic daq_full = 1'b0;
  logic [4*SEL_W-1:0] lut_sel;
  logic [15:0] lut_tab = '0;
  logic [N_CLS*X_W-1:0] cls_use, cls_pol;
  logic [N_CLS-1:0] cls_bcm_en, cls_rnd_en, cls_pf_en, cls_rare;
  logic [N_CLS*BCM_W-1:0] cls_bcm_sel;
  logic [N_CLS*RND_W-1:0] cls_rnd_sel;
  logic [N_CLS*DS_W-1:0]  cls_div;
  logic [N_CLS*CLU_W-1:0] cls_clu;
  logic [N_CLS-1:0] class_fired;
  logic [N_CLU-1:0] cluster_fired;
  logic [N_CLS*CNT_W-1:0] scl_match, scl_fired;

  // bench-side configuration
  logic [X_W-1:0] b_use [N_CLS];
  logic [X_W-1:0] b_pol [N_CLS];
  logic b_bcm_en [N_CLS];
  int   b_bcm_sel[N_CLS];
  logic b_rnd_en [N_CLS];
  int   b_rnd_sel[N_CLS];
  logic b_pf_en  [N_CLS];
  logic b_rare   [N_CLS];
  int   b_div    [N_CLS];
  int   b_clu    [N_CLS];
  int   b_lsel   [4];

  // reference model state
  int ds_cnt [N_CLS];
  int m_sm   [N_CLS];
  int m_sf   [N_CLS];
  logic [N_CLS-1:0] exp_fire;
  logic [N_CLU-1:0] exp_clu;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < N_CLS; c++) begin
      cls_use[c*X_W +: X_W]         = b_use[c];
      cls_pol[c*X_W +: X_W]         = b_pol[c];
      cls_bcm_en[c]                 = b_bcm_en[c];
      cls_bcm_sel[c*BCM_W +: BCM_W] = BCM_W'(b_bcm_sel[c]);
      cls_rnd_en[c]                 = b_rnd_en[c];
      cls_rnd_sel[c*RND_W +: RND_W] = RND_W'(b_rnd_sel[c]);
      cls_pf_en[c]                  = b_pf_en[c];
      cls_rare[c]                   = b_rare[c];
      cls_div[c*DS_W +: DS_W]       = DS_W'(b_div[c]);
      cls_clu[c*CLU_W +: CLU_W]     = CLU_W'(b_clu[c]);
    end
    for (int i = 0; i < 4; i++) lut_sel[i*SEL_W +: SEL_W] = SEL_W'(b_lsel[i]);
  end

  trig_class_eval #(
    .N_IN(N_IN), .N_CLS(N_CLS), .N_CLU(N_CLU), .N_BCM(N_BCM),
    .N_RND(N_RND), .DS_W(DS_W), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .bc_mask(bc_mask),
    .rnd_trig(rnd_trig), .pf_ok(pf_ok), .daq_full(daq_full),
    .lut_sel(lut_sel), .lut_tab(lut_tab), .cls_use(cls_use), .cls_pol(cls_pol),
    .cls_bcm_en(cls_bcm_en), .cls_bcm_sel(cls_bcm_sel), .cls_rnd_en(cls_rnd_en),
    .cls_rnd_sel(cls_rnd_sel), .cls_pf_en(cls_pf_en), .cls_rare(cls_rare),
    .cls_div(cls_div), .cls_clu(cls_clu), .class_fired(class_fired),
    .cluster_fired(cluster_fired), .scl_match(scl_match), .scl_fired(scl_fired)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model of one clock edge with the inputs now applied
  task automatic model_step();
    logic [X_W-1:0] x;
    int a;
    exp_clu = '0;
    a = 0;
    for (int i = 0; i < 4; i++) if (trig_in[b_lsel[i]]) a += (1 << i);
    x = {lut_tab[a], trig_in};
    for (int c = 0; c < N_CLS; c++) begin
      bit hit, gate, qual, f;
      hit = (b_use[c] != '0);
      for (int b = 0; b < X_W; b++)
        if (b_use[c][b] && (x[b] == b_pol[c][b])) hit = 0;
      gate = 1;
      if (b_bcm_en[c] && !bc_mask[b_bcm_sel[c]]) gate = 0;
      if (b_rnd_en[c] && !rnd_trig[b_rnd_sel[c]]) gate = 0;
      if (b_pf_en[c] && !pf_ok) gate = 0;
      if (daq_full && !b_rare[c]) gate = 0;
      qual = hit && gate;
      f = qual && (ds_cnt[c] == 0);
      if (qual) ds_cnt[c] = (ds_cnt[c] + 1 >= b_div[c]) ? 0 : ds_cnt[c] + 1;
      if (hit) m_sm[c] = (m_sm[c] + 1) % 65536;
      if (f)   m_sf[c] = (m_sf[c] + 1) % 65536;
      exp_fire[c] = f;
      if (f && b_clu[c] < N_CLU) exp_clu[b_clu[c]] = 1'b1;
    end
  endtask

  task automatic compare_all();
    string tags [N_CLS];
    tags = '{"R2 plain", "R2 polarity", "R3 lut", "R4 empty",
             "R5 gates", "R6 rare", "R7 downscale", "R8 registered"};
    for (int c = 0; c < N_CLS; c++) begin
      chk(tags[c], 64'(class_fired[c]), 64'(exp_fire[c]));
      chk("R10 scalers", {scl_match[c*CNT_W +: CNT_W], scl_fired[c*CNT_W +: CNT_W]},
          {16'(m_sm[c]), 16'(m_sf[c])});
    end
    chk("R9 cluster", 64'(cluster_fired), 64'(exp_clu));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N_CLS; c++) begin
      b_use[c] = '0; b_pol[c] = '0; b_bcm_en[c] = 0; b_bcm_sel[c] = 0;
      b_rnd_en[c] = 0; b_rnd_sel[c] = 0; b_pf_en[c] = 0; b_rare[c] = 0;
      b_div[c] = 0; b_clu[c] = 0; ds_cnt[c] = 0; m_sm[c] = 0; m_sf[c] = 0;
    end
    for (int i = 0; i < 4; i++) b_lsel[i] = 0;
    exp_fire = '0;
    exp_clu  = '0;

    repeat (3) @(negedge clk);
    chk("R1 reset class", 64'(class_fired), 64'd0);
    chk("R1 reset cluster", 64'(cluster_fired), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle class", 64'(class_fired), 64'd0);
    chk("R1 scalers zero", 64'(|{scl_match, scl_fired}), 64'd0);

    // class configuration
    b_use[0] = X_W'(1) << 0;
    b_use[1] = (X_W'(1) << 1) | (X_W'(1) << 2);
    b_pol[1] = X_W'(1) << 2;
    b_clu[1] = 1;
    b_use[2] = X_W'(1) << N_IN;
    b_clu[2] = 2;
    for (int i = 0; i < 4; i++) b_lsel[i] = 3 + i;
    lut_tab = 16'h6996;
    b_pol[3] = '1;
    b_clu[3] = 3;
    b_use[4] = X_W'(1) << 7;
    b_bcm_en[4] = 1; b_bcm_sel[4] = 2;
    b_rnd_en[4] = 1; b_rnd_sel[4] = 1;
    b_clu[4] = 4;
    b_use[5] = X_W'(1) << 8;
    b_pol[5] = X_W'(1) << 8;
    b_rare[5] = 1; b_pf_en[5] = 1;
    b_clu[5] = 5;
    b_use[6] = X_W'(1) << 9;
    b_div[6] = 3;
    b_clu[6] = 5;
    b_use[7] = (X_W'(1) << 10) | (X_W'(1) << 11);
    b_clu[7] = 7;

    for (int cyc = 0; cyc < 600; cyc++) begin
      trig_in  = N_IN'($urandom);
      if (cyc >= 300 && cyc < 340) trig_in[9] = 1'b1;
      bc_mask  = N_BCM'($urandom);
      rnd_trig = N_RND'($urandom);
      pf_ok    = 1'($urandom);
      daq_full = ((cyc / 16) % 2) == 1;
      if (cyc == 450) b_div[6] = 1;
      #1;
      model_step();
      @(negedge clk);
      compare_all();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule